// File: doc/BRIEF.md
# Serial Register Target with Block Transfers

This block is a two-wire serial bus target that opens a bank of 8-bit control registers to a bus master. Both bus lines are oversampled on the system clock. The block finds START, repeated START and STOP conditions and answers only to its own 7-bit address. It acknowledges bytes and returns read data by pulling SDA low through an open-drain enable. Every register write that takes effect is also announced to the surrounding logic as a one-cycle strobe, together with the index and the data.

A master may write a single register by sending the index and then the data. It may send only an index, which moves the stored pointer. It may read from the stored pointer directly, or it may write an index and then issue a repeated START for the read. A command byte of zero selects block mode. In a block write the next byte is a byte count, and the data that follows fills the bank from index 0 upward. Reads and writes both advance the pointer, which wraps from the last register back to the first. The two highest registers hold fixed identification codes and cannot be changed.

Top module: `i2c_regbank_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0x69. Bit 0 selects the direction, with 1 meaning read. Any other address gets no acknowledge, and the block stays silent until the next START.
- R2: After the address, the first byte written is the index. Each later data byte is acknowledged and written at the current index, and the index then advances. Each write that takes effect gives exactly one `regWrStb` pulse carrying that index and data.
- R3: A write transfer that ends after the index byte changes no register. It only moves the stored index.
- R4: A read that starts directly after START uses the stored index. Every byte sent advances the index, and the index wraps from 20 to 0.
- R5: An index write followed by a repeated START and a read returns the data starting at the index just written.
- R6: When the master does not acknowledge a read byte, the read ends. SDA is released and stays released until the next START.
- R7: An index byte of 0x00 selects block mode with the index at 0. In a block write the next byte is a count N. The N data bytes after it go to indices 0..N-1. Any further data byte is not acknowledged and not written.
- R8: Register 19 reads as 0x57 and register 20 reads as 0x21. Writes to either one are acknowledged but change nothing and give no strobe.
- R9: The block changes its SDA drive only while SCL is low.
- R10: A START or STOP at any bit position abandons the current byte. A byte cut short by STOP is never written.
- R11: After reset SDA is released, no strobe is active, registers 0..18 read 0x00 and the stored index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When 1, the pad pulls SDA low |
| regWrStb | output | 1 | One-cycle pulse for each register write that takes effect |
| regWrIdx | output | 8 | Index of the register written |
| regWrData | output | 8 | Value written |

## Verification
The bench goes after the pointer's edges. Reads and writes run past index 20 and must wrap to 0, and a design with the wrong wrap would return stale or zero data where an ID code belongs. A block write is sent with one byte more than its count; a design that ignores the count would write an extra register and acknowledge that byte. A byte write runs across the two ID registers, and a design without the write guard would give strobes there and change their read values. A START in the middle of the address and a STOP in the middle of a data byte are both injected; a design that does not reset its bit state would decode the next byte out of alignment or commit the partial byte.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } ctl_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_CNT,
    K_DATA
  } byte_kind_e;

  typedef struct packed {
    logic rxShift;
    logic idxLoad;
    logic cntLoad;
    logic wrReg;
    logic txLoad;
    logic txShift;
  } dp_ctrl_t;

endpackage

// File: rtl/i2creg_line_sync.sv
module i2creg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/i2creg_ctrl.sv
module i2creg_ctrl
  import i2creg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclRise,
  input  logic     sclFall,
  input  logic     startDet,
  input  logic     stopDet,
  input  logic     sdaLvl,
  input  logic [7:0] rxByte,
  input  logic     txMsb,
  input  logic     wrAllowed,
  output dp_ctrl_t ctl,
  output logic     sdaOe,
  output logic     ctlIdle
);
  ctl_state_e state, stN;
  byte_kind_e kind, kindN;
  logic [3:0] bitCnt, bitN;
  logic ackDrive, ackN;
  logic goTx, goTxN;
  logic mNack, nackN;

  always_comb begin
    stN   = state;
    kindN = kind;
    bitN  = bitCnt;
    ackN  = ackDrive;
    goTxN = goTx;
    nackN = mNack;
    ctl   = '0;
    if (stopDet) begin
      stN = ST_IDLE;
    end else if (startDet) begin
      stN   = ST_RX;
      kindN = K_ADDR;
      bitN  = 4'd0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            ctl.rxShift = 1'b1;
            bitN        = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            stN   = ST_ACK;
            goTxN = 1'b0;
            case (kind)
              K_ADDR: begin
                ackN  = (rxByte[7:1] == DEV_ADDR);
                goTxN = rxByte[0];
                kindN = K_CMD;
              end
              K_CMD: begin
                ackN        = 1'b1;
                ctl.idxLoad = 1'b1;
                kindN       = (rxByte == 8'h00) ? K_CNT : K_DATA;
              end
              K_CNT: begin
                ackN        = 1'b1;
                ctl.cntLoad = 1'b1;
                kindN       = K_DATA;
              end
              default: begin
                ackN      = wrAllowed;
                ctl.wrReg = wrAllowed;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitN = 4'd0;
            if (!ackDrive) begin
              stN = ST_IDLE;
            end else if (goTx) begin
              stN        = ST_TX;
              ctl.txLoad = 1'b1;
            end else begin
              stN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stN = ST_MACK;
            end else begin
              ctl.txShift = 1'b1;
              bitN        = bitCnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            nackN = sdaLvl;
          end else if (sclFall) begin
            if (mNack) begin
              stN = ST_IDLE;
            end else begin
              stN        = ST_TX;
              ctl.txLoad = 1'b1;
              bitN       = 4'd0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      bitCnt   <= 4'd0;
      ackDrive <= 1'b0;
      goTx     <= 1'b0;
      mNack    <= 1'b1;
    end else begin
      state    <= stN;
      kind     <= kindN;
      bitCnt   <= bitN;
      ackDrive <= ackN;
      goTx     <= goTxN;
      mNack    <= nackN;
    end
  end

  assign sdaOe   = (state == ST_ACK && ackDrive) || (state == ST_TX && !txMsb);
  assign ctlIdle = (state == ST_IDLE);
endmodule

// File: rtl/i2creg_datapath.sv
module i2creg_datapath
  import i2creg_pkg::*;
#(
  parameter int         NUM_REGS = 21,
  parameter logic [7:0] ID_CODE0 = 8'h57,
  parameter logic [7:0] ID_CODE1 = 8'h21
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_ctrl_t   ctl,
  input  logic       sdaLvl,
  output logic [7:0] rxByte,
  output logic       txMsb,
  output logic       wrAllowed,
  output logic       regWrStb,
  output logic [7:0] regWrIdx,
  output logic [7:0] regWrData
);
  localparam int NUM_RW = NUM_REGS - 2;
  localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);
  localparam logic [7:0] ID0_IDX  = 8'(NUM_RW);
  localparam logic [7:0] ID1_IDX  = 8'(NUM_RW + 1);

  logic [7:0] regFile [NUM_RW];
  logic [7:0] idx;
  logic [7:0] idxNext;
  logic [7:0] remain;
  logic       blkMode;
  logic [7:0] rxSh;
  logic [7:0] txSh;
  logic [7:0] rdVal;
  logic       idxWritable;

  assign idxNext     = (idx >= LAST_IDX) ? 8'h00 : idx + 8'h01;
  assign idxWritable = (idx < ID0_IDX);
  assign wrAllowed   = !blkMode || (remain != 8'h00);
  assign rxByte      = rxSh;
  assign txMsb       = txSh[7];

  for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= 8'h00;
      else if (ctl.wrReg && idx == 8'(g)) regFile[g] <= rxSh;
    end
  end

  always_comb begin
    rdVal = 8'h00;
    for (int i = 0; i < NUM_RW; i++) begin
      if (idx == 8'(i)) rdVal = regFile[i];
    end
    if (idx == ID0_IDX) rdVal = ID_CODE0;
    if (idx == ID1_IDX) rdVal = ID_CODE1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx       <= 8'h00;
      remain    <= 8'h00;
      blkMode   <= 1'b0;
      rxSh      <= 8'h00;
      txSh      <= 8'hFF;
      regWrStb  <= 1'b0;
      regWrIdx  <= 8'h00;
      regWrData <= 8'h00;
    end else begin
      regWrStb <= ctl.wrReg && idxWritable;
      if (ctl.rxShift) rxSh <= {rxSh[6:0], sdaLvl};
      if (ctl.idxLoad) begin
        idx     <= rxSh;
        blkMode <= (rxSh == 8'h00);
      end
      if (ctl.cntLoad) remain <= rxSh;
      if (ctl.wrReg) begin
        if (idxWritable) begin
          regWrIdx  <= idx;
          regWrData <= rxSh;
        end
        idx <= idxNext;
        if (blkMode) remain <= remain - 8'h01;
      end
      if (ctl.txLoad) begin
        txSh <= rdVal;
        idx  <= idxNext;
      end else if (ctl.txShift) begin
        txSh <= {txSh[6:0], 1'b1};
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2creg_pkg::*;
#(
  parameter int         NUM_REGS    = 21,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] ID_CODE0    = 8'h57,
  parameter logic [7:0] ID_CODE1    = 8'h21,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic       regWrStb,
  output logic [7:0] regWrIdx,
  output logic [7:0] regWrData
);
  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic txMsb, wrAllowed, ctlIdle;
  dp_ctrl_t ctl;

  i2creg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2creg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txMsb(txMsb), .wrAllowed(wrAllowed),
    .ctl(ctl), .sdaOe(sdaOe), .ctlIdle(ctlIdle)
  );

  i2creg_datapath #(.NUM_REGS(NUM_REGS), .ID_CODE0(ID_CODE0), .ID_CODE1(ID_CODE1)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txMsb(txMsb), .wrAllowed(wrAllowed),
    .regWrStb(regWrStb), .regWrIdx(regWrIdx), .regWrData(regWrData)
  );
endmodule

// File: rtl/i2creg_checker.sv
module i2creg_checker #(
  parameter int NUM_REGS = 21
) (
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       sclLvl,
  input logic       startDet,
  input logic       stopDet,
  input logic       ctlIdle,
  input logic       regWrStb,
  input logic [7:0] regWrIdx
);
  // R9: drive changes only with the synchronised clock line low
  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLvl);

  // R8: the two ID registers never receive a write strobe
  p_ro_unwritten_r8: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |-> (regWrIdx < 8'(NUM_REGS - 2)));

  // R2: each write is a single-cycle pulse
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |=> !regWrStb);

  // R10: a START releases the line
  p_start_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  // R10: a STOP returns the controller to idle
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> ctlIdle);

  // R1: no drive while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctlIdle |-> !sdaOe);
endmodule

bind i2c_regbank_target i2creg_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclLvl(sclLvl),
  .startDet(startDet), .stopDet(stopDet), .ctlIdle(ctlIdle),
  .regWrStb(regWrStb), .regWrIdx(regWrIdx)
);

// File: tb/sim_i2c_regbank_target.sv
module sim_i2c_regbank_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic busSda;
  logic sdaOe, regWrStb;
  logic [7:0] regWrIdx, regWrData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int mRegs[21];
  int mIdx = 0;
  bit mBlk = 1'b0;
  int mRem = 0;
  int expIdx[$];
  int expDat[$];
  logic [7:0] pay[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign busSda = mSda & ~sdaOe;

  i2c_regbank_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda),
    .sdaOe(sdaOe), .regWrStb(regWrStb), .regWrIdx(regWrIdx), .regWrData(regWrData)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int regVal(input int i);
    if (i < 19) return mRegs[i];
    if (i == 19) return 32'h57;
    if (i == 20) return 32'h21;
    return 0;
  endfunction

  function automatic int nextIdx(input int i);
    return (i >= 20) ? 0 : i + 1;
  endfunction

  // write strobe monitor against the model's queue (R2, R8)
  always @(negedge clk) begin
    if (rstN && regWrStb) begin
      if (expIdx.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected strobe: actual idx %0d data 0x%0h expected none",
                 regWrIdx, regWrData);
      end else begin
        checkEq("R2 strobe index", int'(regWrIdx), expIdx.pop_front());
        checkEq("R2 strobe data", int'(regWrData), expDat.pop_front());
      end
    end
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
    end
  endtask

  task automatic writeByte(input logic [7:0] b, output bit ack);
    sendBits(b, 8);
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); ack = ~busSda; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic readByte(input bit ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); mScl = 1'b1; waitQ(); b[i] = busSda; waitQ(); mScl = 1'b0;
    end
    waitQ();
    mSda = ~ackIt; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
    mSda = 1'b1;
  endtask

  task automatic doWrite(input string tag, input logic [6:0] a, input bit stopAtEnd);
    bit ack;
    bit exp;
    busStart();
    writeByte({a, 1'b0}, ack);
    checkEq({tag, " R1 address ack"}, int'(ack), int'(a == ADDR));
    if (a != ADDR) begin busStop(); return; end
    for (int i = 0; i < pay.size(); i++) begin
      int b = int'(pay[i]);
      if (i == 0) begin
        exp = 1'b1;
        mBlk = (b == 0);
        mIdx = b;
      end else if (i == 1 && mBlk) begin
        exp = 1'b1;
        mRem = b;
      end else begin
        exp = !mBlk || (mRem > 0);
        if (exp) begin
          if (mIdx < 19) begin
            mRegs[mIdx] = b;
            expIdx.push_back(mIdx);
            expDat.push_back(b);
          end
          mIdx = nextIdx(mIdx);
          if (mBlk) mRem--;
        end
      end
      writeByte(pay[i], ack);
      checkEq({tag, " byte ack"}, int'(ack), int'(exp));
      if (!exp) break;
    end
    if (stopAtEnd) busStop();
  endtask

  task automatic doRead(input string tag, input logic [6:0] a, input int n);
    bit ack;
    logic [7:0] b;
    busStart();
    writeByte({a, 1'b1}, ack);
    checkEq({tag, " R1 read address ack"}, int'(ack), int'(a == ADDR));
    if (a != ADDR) begin busStop(); return; end
    for (int k = 0; k < n; k++) begin
      int e = regVal(mIdx);
      mIdx = nextIdx(mIdx);
      readByte(k < n - 1, b);
      checkEq({tag, " read data"}, int'(b), e);
    end
    checkEq("R6 SDA released after NACK", int'(sdaOe), 0);
    busStop();
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < 21; i++) mRegs[i] = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R11 reset sdaOe", int'(sdaOe), 0);
    checkEq("R11 reset strobe", int'(regWrStb), 0);
    // R11/R8/R4: stored index 0 after reset, read whole bank and wrap
    doRead("R11 R4 R8 stored-index sweep", ADDR, 22);
    // R2: single byte write
    pay = '{8'd5, 8'hA5};
    doWrite("R2", ADDR, 1'b1);
    // R5: index then repeated START read
    pay = '{8'd5};
    doWrite("R5", ADDR, 1'b0);
    doRead("R5 repeated start", ADDR, 1);
    // R8: write across the ID registers, index wraps to 0
    pay = '{8'd17, 8'h11, 8'h22, 8'h33, 8'h44};
    doWrite("R8", ADDR, 1'b1);
    doRead("R4 wrap stored index", ADDR, 1);
    // R3: index only, then read from stored index
    pay = '{8'd18};
    doWrite("R3", ADDR, 1'b1);
    doRead("R3 R8 read after index-only", ADDR, 3);
    // R1: foreign addresses
    pay = '{8'd3, 8'h77};
    doWrite("R1 foreign write", 7'h6A, 1'b1);
    doRead("R1 foreign read", 7'h2B, 1);
    // R7: block write with one byte past the count
    pay = '{8'h00, 8'd3, 8'hB0, 8'hB1, 8'hB2, 8'hB3};
    doWrite("R7 block", ADDR, 1'b1);
    pay = '{8'h00};
    doWrite("R7 block pointer", ADDR, 1'b0);
    doRead("R7 block readback", ADDR, 4);
    // R10: START in the middle of an address byte
    busStart();
    sendBits(8'hD2, 4);
    pay = '{8'd7, 8'h3C};
    doWrite("R10 restart mid-byte", ADDR, 1'b1);
    // R10: STOP in the middle of a data byte
    busStart();
    writeByte(8'hD2, ack);
    checkEq("R10 address ack", int'(ack), 1);
    writeByte(8'd8, ack);
    checkEq("R10 index ack", int'(ack), 1);
    mIdx = 8; mBlk = 1'b0;
    sendBits(8'h99, 5);
    busStop();
    doRead("R10 partial byte not written", ADDR, 1);
    pay = '{8'd6};
    doWrite("R10 pointer", ADDR, 1'b0);
    doRead("R10 restart write landed", ADDR, 2);
    repeat (20) @(negedge clk);
    checkEq("R2 pending writes", expIdx.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule